// File: doc/BRIEF.md
# CPU Core Clock Divider and Source Select

This block derives the processor core clock from two sources: a PLL and a crystal. A pre-selector picks which source feeds a divider stage. The divider offers fixed ratios of 1, 2 and 3, and a programmable even ratio of 2×N. A final selector then passes either the divider result or the crystal itself to the output. Software controls the block through two 32-bit words on a simple valid/write/address/data bus. A ratio helper input translates a requested integer divide ratio into the path-select and N fields. A readback output reports the ratio currently programmed.

The whole block runs on one system clock. Each source is presented as a strobe input, and one strobe stands for one edge of that source, rising or falling. A divide ratio K means the output toggles once every K source edges. This gives a 50% duty output for every ratio, including 3, because an odd count of edges covers both source edge polarities. New ratio settings take effect only at the start of a low phase of the divider output, so no shortened pulse ever reaches the output.

Top module: `cpuclk_path`

## Requirements
- R1: After reset, both control words read zero, clk_out is low and ratio_rd reads 1. A zero mode word selects the crystal bypass.
- R2: Mode word bit 7 is the output select. When it is 0, clk_out is a level that toggles once per crystal strobe. When it is 1, clk_out carries the divider output. clk_out is registered one cycle after the selected level.
- R3: Mode word bit 0 is the source select. When it is 1, the divider advances on PLL strobes. When it is 0, the divider advances on crystal strobes. Strobes from the other source do not change the divider.
- R4: Mode word bits [3:2] form the path select. Codes 0, 1 and 2 make the divider output toggle every 1, 2 or 3 source strobes, so high and low phases are equal in length.
- R5: Path code 3 makes the output toggle every 2×N source strobes. N is the 9-bit field at bits [28:20] of the divide word.
- R6: When path code 3 is active with N = 0, the divider output is held low and ratio_rd reads 0. Programming a legal setting afterwards restarts the divider without waiting for an output edge.
- R7: A ratio request D with D ≤ 3 writes path code D−1 and N = 0. A request of 0 is treated like 1. A request above 3 writes path code 3 and N = floor(D/2), so odd ratios round down to the next even ratio.
- R8: ratio_rd shows the path code + 1 for codes 0 to 2, and 2×N for code 3. It reflects the control words one cycle after they change.
- R9: Path code and N are copied into the divider only at the strobe that drives its output from high to low, or at any cycle while the active setting is the stalled one. A high phase in progress always completes at the old ratio, and the following low phase already uses the new ratio.
- R10: A bus write replaces the whole addressed word, and every bit is stored. A ratio request changes only the path-select and N fields and keeps all other bits. When both occur in the same cycle, the request's fields override the written data in those fields.
- R11: Word address 0 is the mode word and address 1 is the divide word. A read returns the addressed word on bus_rdata one cycle later and holds it until the next read. Other addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_tick | input | 1 | One PLL source edge per asserted cycle |
| xtal_tick | input | 1 | One crystal source edge per asserted cycle |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| ratio_req_valid | input | 1 | Apply a requested divide ratio |
| ratio_req | input | 10 | Requested divide ratio D |
| ratio_rd | output | 10 | Effective divide ratio readback |
| clk_out | output | 1 | Core clock level |

## Verification
The hardest case to reach is reprogramming the ratio while the divider output is high. The port-level check must show that the high phase finishes at the old length and that the next low phase already uses the new one. The bench runs the divider with one source strobe every cycle and waits for a rising clk_out. It then issues a ratio request inside that high phase and measures both phase lengths in cycles. The stalled setting (code 3 with N = 0) is reached by a ratio request followed by a raw bus write that clears N. Recovery from the stall is then exercised with a further request.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
  // Field placement inside the mode word (word address 0)
  localparam int unsigned OUTSEL_BIT = 7;
  localparam int unsigned SRCSEL_BIT = 0;
  localparam int unsigned PATH_LSB   = 2;
  localparam int unsigned PATH_W     = 2;
  // Field placement inside the divide word (word address 1)
  localparam int unsigned NDIV_LSB   = 20;
  // Word indices
  localparam int unsigned WORD_MODE  = 0;
  localparam int unsigned WORD_DIV   = 1;
  localparam int unsigned NUM_WORDS  = 2;
  // Path codes
  localparam logic [PATH_W-1:0] PATH_BY1  = 2'd0;
  localparam logic [PATH_W-1:0] PATH_PROG = 2'd3;
endpackage

// File: rtl/cpuclk_regs.sv
module cpuclk_regs
  import cpuclk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned N_W    = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                req_valid,
  input  logic [N_W:0]        req_ratio,
  output logic                out_sel,
  output logic                src_sel,
  output logic [PATH_W-1:0]   path_sel,
  output logic [N_W-1:0]      div_n
);
  localparam int unsigned RATIO_W = N_W + 1;

  logic [NUM_WORDS-1:0][DATA_W-1:0] words;
  logic [PATH_W-1:0]                req_path;
  logic [N_W-1:0]                   req_n;
  logic [DATA_W-1:0]                rd_word;

  // Translate a requested ratio into field values
  always_comb begin
    if (req_ratio <= RATIO_W'(3)) begin
      req_n = '0;
      if (req_ratio == '0) req_path = PATH_BY1;
      else                 req_path = PATH_W'(req_ratio - RATIO_W'(1));
    end else begin
      req_path = PATH_PROG;
      req_n    = req_ratio[RATIO_W-1:1];
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] word_d;

    always_comb begin
      word_d = word_q;
      if (bus_valid && bus_write && (bus_addr == ADDR_W'(g)))
        word_d = bus_wdata;
      if (req_valid) begin
        if (g == WORD_MODE) word_d[PATH_LSB +: PATH_W] = req_path;
        else                word_d[NDIV_LSB +: N_W]    = req_n;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) word_q <= '0;
      else     word_q <= word_d;
    end

    assign words[g] = word_q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_WORDS; i++)
      if (bus_addr == ADDR_W'(i)) rd_word = words[i];
  end

  always_ff @(posedge clk) begin
    if (rst)                        bus_rdata <= '0;
    else if (bus_valid && !bus_write) bus_rdata <= rd_word;
  end

  assign out_sel  = words[WORD_MODE][OUTSEL_BIT];
  assign src_sel  = words[WORD_MODE][SRCSEL_BIT];
  assign path_sel = words[WORD_MODE][PATH_LSB +: PATH_W];
  assign div_n    = words[WORD_DIV][NDIV_LSB +: N_W];
endmodule

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
  import cpuclk_pkg::*;
#(
  parameter int unsigned N_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [PATH_W-1:0] sel_in,
  input  logic [N_W-1:0]    n_in,
  output logic              div_q
);
  localparam int unsigned K_W = N_W + 1;

  logic [PATH_W-1:0] sh_sel;
  logic [N_W-1:0]    sh_n;
  logic [K_W-1:0]    cnt;
  logic [K_W-1:0]    k_len;
  logic [K_W-1:0]    k_last;
  logic              stalled;

  // Edges per output phase for the active (shadow) setting
  always_comb begin
    if (sh_sel == PATH_PROG) k_len = {sh_n, 1'b0};
    else                     k_len = K_W'(sh_sel) + K_W'(1);
    k_last  = k_len - K_W'(1);
    stalled = (k_len == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= 1'b0;
      cnt    <= '0;
      sh_sel <= PATH_BY1;
      sh_n   <= '0;
    end else if (stalled) begin
      div_q  <= 1'b0;
      cnt    <= '0;
      sh_sel <= sel_in;
      sh_n   <= n_in;
    end else if (tick) begin
      if (cnt == k_last) begin
        cnt   <= '0;
        div_q <= ~div_q;
        if (div_q) begin
          sh_sel <= sel_in;
          sh_n   <= n_in;
        end
      end else begin
        cnt <= cnt + K_W'(1);
      end
    end
  end
endmodule

// File: rtl/cpuclk_outstage.sv
module cpuclk_outstage
  import cpuclk_pkg::*;
#(
  parameter int unsigned N_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xtal_tick,
  input  logic              out_sel,
  input  logic              div_q,
  input  logic [PATH_W-1:0] path_sel,
  input  logic [N_W-1:0]    div_n,
  output logic              clk_out,
  output logic [N_W:0]      ratio_rd
);
  localparam int unsigned RATIO_W = N_W + 1;

  logic xtal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_q   <= 1'b0;
      clk_out  <= 1'b0;
      ratio_rd <= RATIO_W'(1);
    end else begin
      if (xtal_tick) xtal_q <= ~xtal_q;
      clk_out <= out_sel ? div_q : xtal_q;
      if (path_sel == PATH_PROG) ratio_rd <= {div_n, 1'b0};
      else                       ratio_rd <= RATIO_W'(path_sel) + RATIO_W'(1);
    end
  end
endmodule

// File: rtl/cpuclk_path.sv
module cpuclk_path
  import cpuclk_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned N_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pll_tick,
  input  logic              xtal_tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ratio_req_valid,
  input  logic [N_W:0]      ratio_req,
  output logic [N_W:0]      ratio_rd,
  output logic              clk_out
);
  logic              out_sel;
  logic              src_sel;
  logic [PATH_W-1:0] path_sel;
  logic [N_W-1:0]    div_n;
  logic              src_tick;
  logic              div_q;

  cpuclk_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_W(N_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_valid (ratio_req_valid),
    .req_ratio (ratio_req),
    .out_sel   (out_sel),
    .src_sel   (src_sel),
    .path_sel  (path_sel),
    .div_n     (div_n)
  );

  assign src_tick = src_sel ? pll_tick : xtal_tick;

  cpuclk_divider #(.N_W(N_W)) u_div (
    .clk    (clk),
    .rst    (rst),
    .tick   (src_tick),
    .sel_in (path_sel),
    .n_in   (div_n),
    .div_q  (div_q)
  );

  cpuclk_outstage #(.N_W(N_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .xtal_tick (xtal_tick),
    .out_sel   (out_sel),
    .div_q     (div_q),
    .path_sel  (path_sel),
    .div_n     (div_n),
    .clk_out   (clk_out),
    .ratio_rd  (ratio_rd)
  );
endmodule

// File: rtl/cpuclk_path_chk.sv
module cpuclk_path_chk #(
  parameter int unsigned N_W = 9
) (
  input logic         clk,
  input logic         rst,
  input logic         clk_out,
  input logic [N_W:0] ratio_rd,
  input logic         ratio_req_valid,
  input logic [N_W:0] ratio_req
);
  localparam int unsigned RATIO_W = N_W + 1;

  // R1: the first cycle after reset shows the reset outputs
  a_r1_reset_outputs: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!clk_out && ratio_rd == RATIO_W'(1)));

  // R7, R8: a small ratio request shows up on the readback two cycles on
  a_r7_small_request: assert property (@(posedge clk) disable iff (rst)
    (ratio_req_valid && ratio_req >= RATIO_W'(1) && ratio_req <= RATIO_W'(3))
      |=> ##1 (ratio_rd == $past(ratio_req, 2)));
endmodule

module cpuclk_div_chk #(
  parameter int unsigned N_W = 9
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           div_q,
  input logic [1:0]     sh_sel,
  input logic [N_W-1:0] sh_n,
  input logic [N_W:0]   cnt
);
  logic stall_now;
  assign stall_now = (sh_sel == 2'd3) && (sh_n == '0);

  // R9: the active setting only changes at a falling output or out of a stall
  a_r9_load_at_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sh_sel) || !$stable(sh_n))
      |-> (($past(div_q) && !div_q) || ($past(sh_sel) == 2'd3 && $past(sh_n) == '0)));

  // R6: a stalled setting keeps the divider output low
  a_r6_stall_low: assert property (@(posedge clk) disable iff (rst)
    stall_now |-> !div_q);

  // R3: without a selected source strobe the divider does not move
  a_r3_no_strobe_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !stall_now) |=> ($stable(div_q) && $stable(cnt)));
endmodule

bind cpuclk_path cpuclk_path_chk #(.N_W(N_W)) u_path_chk (
  .clk             (clk),
  .rst             (rst),
  .clk_out         (clk_out),
  .ratio_rd        (ratio_rd),
  .ratio_req_valid (ratio_req_valid),
  .ratio_req       (ratio_req)
);

bind cpuclk_divider cpuclk_div_chk #(.N_W(N_W)) u_div_chk (
  .clk    (clk),
  .rst    (rst),
  .tick   (tick),
  .div_q  (div_q),
  .sh_sel (sh_sel),
  .sh_n   (sh_n),
  .cnt    (cnt)
);

// File: tb/test_cpuclk_path.sv
module test_cpuclk_path;
  localparam int unsigned N_W = 9;
  localparam int unsigned RW  = N_W + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pll_tick = 1'b0;
  logic          xtal_tick = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [1:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          ratio_req_valid = 1'b0;
  logic [RW-1:0] ratio_req = '0;
  logic [RW-1:0] ratio_rd;
  logic          clk_out;

  always #5 clk = ~clk;

  cpuclk_path i_cpuclk_path (
    .clk(clk), .rst(rst), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ratio_req_valid(ratio_req_valid), .ratio_req(ratio_req),
    .ratio_rd(ratio_rd), .clk_out(clk_out));

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Source strobe generator
  int cyc = 0;
  bit pll_en = 1, xtal_en = 1;
  int pll_per = 1, xtal_per = 5;
  always @(negedge clk) begin
    cyc++;
    pll_tick  <= pll_en && (cyc % pll_per == 0);
    xtal_tick <= xtal_en && (cyc % xtal_per == 0);
  end

  // Behavioural reference model
  logic [31:0] m_r0, m_r1, m_rd;
  int  m_ratio, m_cnt, m_sh_sel, m_sh_n;
  bit  m_out, m_dq, m_xq;

  function automatic int ratio_of(input int sel, input int n);
    return (sel < 3) ? sel + 1 : 2 * n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_r0 = 0; m_r1 = 0; m_rd = 0; m_ratio = 1; m_cnt = 0;
      m_sh_sel = 0; m_sh_n = 0; m_out = 0; m_dq = 0; m_xq = 0;
    end else begin
      int k;
      bit tk;
      logic [31:0] n0, n1;
      m_out = m_r0[7] ? m_dq : m_xq;
      if (bus_valid && !bus_write)
        m_rd = (bus_addr == 0) ? m_r0 : (bus_addr == 1) ? m_r1 : 32'h0;
      m_ratio = ratio_of(int'(m_r0[3:2]), int'(m_r1[28:20]));
      tk = m_r0[0] ? pll_tick : xtal_tick;
      if (xtal_tick) m_xq = !m_xq;
      k = ratio_of(m_sh_sel, m_sh_n);
      if (k == 0) begin
        m_dq = 0; m_cnt = 0;
        m_sh_sel = int'(m_r0[3:2]); m_sh_n = int'(m_r1[28:20]);
      end else if (tk) begin
        m_cnt++;
        if (m_cnt == k) begin
          m_cnt = 0;
          m_dq = !m_dq;
          if (!m_dq) begin
            m_sh_sel = int'(m_r0[3:2]); m_sh_n = int'(m_r1[28:20]);
          end
        end
      end
      n0 = m_r0; n1 = m_r1;
      if (bus_valid && bus_write) begin
        if (bus_addr == 0) n0 = bus_wdata;
        else if (bus_addr == 1) n1 = bus_wdata;
      end
      if (ratio_req_valid) begin
        if (ratio_req <= 3) begin
          n0[3:2] = (ratio_req == 0) ? 2'd0 : 2'(ratio_req - 1);
          n1[28:20] = 9'd0;
        end else begin
          n0[3:2] = 2'd3;
          n1[28:20] = 9'(ratio_req / 2);
        end
      end
      m_r0 = n0; m_r1 = n1;
    end
  end

  // Cycle compare against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, {31'b0, clk_out}, {31'b0, m_out}, "clk_out vs model");
      chk(cur_req, {22'b0, ratio_rd}, 32'(m_ratio), "ratio_rd vs model");
      chk(cur_req, bus_rdata, m_rd, "bus_rdata vs model");
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk); bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic req(input int d);
    @(negedge clk); ratio_req_valid = 1; ratio_req = RW'(d);
    @(negedge clk); ratio_req_valid = 0;
    @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (clk_out !== 1'b0) @(negedge clk);
    while (clk_out !== 1'b1) @(negedge clk);
    while (clk_out === 1'b1) begin hi++; @(negedge clk); end
    while (clk_out === 1'b0) begin lo++; @(negedge clk); end
  endtask

  task automatic check_phases(input string r, input int exp);
    int hi, lo;
    measure(hi, lo);
    measure(hi, lo);
    chk(r, 32'(hi), 32'(exp), "high phase length");
    chk(r, 32'(lo), 32'(exp), "low phase length");
  endtask

  initial begin
    logic [31:0] rd;
    int hl, ll, tg;
    logic prev, first;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", {31'b0, clk_out}, 32'h0, "clk_out after reset");
    chk("R1", {22'b0, ratio_rd}, 32'h1, "ratio_rd after reset");
    bus_rd(0, rd); chk("R1", rd, 32'h0, "mode word after reset");
    bus_rd(1, rd); chk("R1", rd, 32'h0, "divide word after reset");

    cur_req = "R2";
    repeat (30) @(negedge clk);

    // Divider path, PLL source, ratio 1
    cur_req = "R4";
    bus_wr(0, 32'h0000_5A81);
    repeat (4) @(negedge clk);
    check_phases("R4", 1);

    cur_req = "R7";
    req(2);
    chk("R8", {22'b0, ratio_rd}, 32'd2, "ratio_rd after request 2");
    bus_rd(0, rd); chk("R10", rd, 32'h0000_5A85, "mode word keeps other bits");
    check_phases("R4", 2);

    req(3);
    chk("R8", {22'b0, ratio_rd}, 32'd3, "ratio_rd after request 3");
    check_phases("R4", 3);

    cur_req = "R5";
    bus_wr(1, 32'h8050_0123);
    req(9);
    chk("R7", {22'b0, ratio_rd}, 32'd8, "odd request rounds down");
    bus_rd(1, rd); chk("R10", rd, 32'h8040_0123, "divide word keeps other bits");
    check_phases("R5", 8);
    req(10);
    chk("R8", {22'b0, ratio_rd}, 32'd10, "ratio_rd after request 10");
    check_phases("R5", 10);

    cur_req = "R3";
    pll_per = 2;
    repeat (100) @(negedge clk);
    pll_per = 1;

    // Reprogram in the middle of a high phase
    cur_req = "R9";
    req(20);
    check_phases("R5", 20);
    while (clk_out !== 1'b0) @(negedge clk);
    while (clk_out !== 1'b1) @(negedge clk);
    hl = 1;
    repeat (3) begin @(negedge clk); if (clk_out === 1'b1) hl++; end
    ratio_req_valid = 1; ratio_req = RW'(2);
    @(negedge clk);
    ratio_req_valid = 0;
    while (clk_out === 1'b1) begin hl++; @(negedge clk); end
    ll = 0;
    while (clk_out === 1'b0) begin ll++; @(negedge clk); end
    chk("R9", 32'(hl), 32'd20, "high phase completes at old ratio");
    chk("R9", 32'(ll), 32'd2, "next low phase uses new ratio");

    // Stalled setting and recovery
    cur_req = "R6";
    req(9);
    bus_wr(1, 32'h0);
    repeat (40) @(negedge clk);
    chk("R6", {22'b0, ratio_rd}, 32'd0, "ratio_rd for stalled setting");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R6", {31'b0, clk_out}, 32'h0, "clk_out held low");
    end
    req(4);
    chk("R8", {22'b0, ratio_rd}, 32'd4, "ratio_rd after recovery");
    check_phases("R6", 4);

    // Source select: crystal strobes stopped, PLL strobes ignored
    cur_req = "R3";
    xtal_en = 0;
    bus_wr(0, 32'h0000_5A8C);
    repeat (5) @(negedge clk);
    first = clk_out;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R3", {31'b0, clk_out}, {31'b0, first}, "PLL strobes ignored on crystal source");
    end
    xtal_en = 1;
    repeat (60) @(negedge clk);

    // Crystal bypass
    cur_req = "R2";
    bus_wr(0, 32'h0);
    repeat (10) @(negedge clk);
    prev = clk_out; tg = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (clk_out !== prev) tg++;
      prev = clk_out;
    end
    chk("R2", 32'(tg), 32'd10, "bypass toggles per crystal strobe");

    // Unmapped address
    cur_req = "R11";
    bus_wr(2, 32'hFFFF_FFFF);
    bus_rd(0, rd); chk("R11", rd, 32'h0, "mode word after unmapped write");
    bus_rd(1, rd); chk("R11", rd, 32'h0020_0000, "divide word after unmapped write");
    bus_rd(2, rd); chk("R11", rd, 32'h0, "unmapped read");

    // Bus write and request in the same cycle
    cur_req = "R10";
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 0; bus_wdata = 32'h0000_3C81;
    ratio_req_valid = 1; ratio_req = RW'(3);
    @(negedge clk);
    bus_valid = 0; bus_write = 0; ratio_req_valid = 0;
    bus_rd(0, rd); chk("R10", rd, 32'h0000_3C89, "request fields win over write");
    bus_rd(1, rd); chk("R10", rd, 32'h0, "request clears N");

    cur_req = "R7";
    req(0);
    chk("R7", {22'b0, ratio_rd}, 32'd1, "request 0 acts as 1");
    check_phases("R7", 1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule